// File: doc/BRIEF.md
# Daisy-Chain Serializer Readout and Fault Checker

This block is the host side of a chain of input serializer devices. Each device presents eight digital input levels. One `start` pulse opens a single chip-select window, and the block clocks the whole chain out over an SPI-style link: SCLK idles low and MISO is sampled on each rising edge, MSB first. The block does not decode byte lengths or frame formats beyond two layouts. In the short layout each device contributes one data byte. In the long layout each device contributes a data byte followed by a status byte.

In the long layout the block checks every device's frame on its own. It recomputes a 5-bit CRC bit by bit as the data byte arrives and compares it with the top five status bits. It also decodes the overtemperature, undervoltage-alarm and undervoltage-warning bits. After the last bit it raises `done` for one cycle. In that same cycle it publishes the input vector, the per-device flag vectors and a per-device `faulting` mask. Software can therefore use the inputs of healthy devices and reject only the devices that are flagged. An option removes the undervoltage flags and the external fault pins from the faulting decision, for chains powered in a way that keeps undervoltage permanently reported. The parameter `FAULT_SHARED` selects between one fault pin for the whole chain and one fault pin per device.

Top module: `chain_reader`

## Requirements
- R1: During one accepted readout `cs_n` is low for exactly 8·NDEV rising SCLK edges in short mode (`mode16`=0) or 16·NDEV in long mode (`mode16`=1), and SCLK is low whenever `cs_n` is high.
- R2: Bytes arrive MSB first. In long mode, byte 2i is device i's data and byte 2i+1 is its status. In short mode, byte i is device i's data. `din_vec[8i+7:8i]` holds device i's data byte, so input channel k is `din_vec[k]`.
- R3: In long mode `crc_err[i]` is 1 exactly when status bits [7:3] differ from the CRC-5 of device i's data byte. The CRC uses generator x^5+x^4+x^2+1, is computed MSB first and starts from zero.
- R4: In long mode `over_temp[i]` equals status bit 1, `uv_alarm[i]` is the inverse of status bit 2, and `uv_warn[i]` is the inverse of status bit 0.
- R5: In short mode `crc_err`, `over_temp`, `uv_alarm` and `uv_warn` all read 0, and only the fault pin can mark a device faulting.
- R6: With `ignore_uv`=0, `faulting[i]` is 1 when device i's fault pin is high, or when, in long mode, the device has a CRC error, overtemperature or an undervoltage alarm. An undervoltage warning alone does not set it.
- R7: With `ignore_uv`=1, `faulting[i]` is affected neither by the fault pin nor by the undervoltage alarm. `uv_alarm`, `uv_warn` and `fault_seen` still report the raw values.
- R8: `done` is a one-cycle pulse. All result outputs change only in the `done` cycle and hold until the next one. A `start` while `busy` is ignored.
- R9: After reset `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, and all result outputs are 0.
- R10: `mode16` and `ignore_uv` are captured when `start` is accepted. Changes to them during a readout have no effect on that readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a readout when idle |
| mode16 | input | 1 | 1: data+status per device, 0: data only |
| ignore_uv | input | 1 | Exclude undervoltage and fault pins from the faulting mask |
| fault_in | input | FAULT_SHARED ? 1 : NDEV | External fault pins, active high |
| miso | input | 1 | Serial data from the chain |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Readout in progress |
| done | output | 1 | One-cycle pulse when results update |
| din_vec | output | NDEV*8 | Input levels, channel k at bit k |
| crc_err | output | NDEV | Per-device CRC mismatch |
| over_temp | output | NDEV | Per-device overtemperature |
| uv_alarm | output | NDEV | Per-device undervoltage alarm |
| uv_warn | output | NDEV | Per-device undervoltage warning |
| fault_seen | output | NDEV | Fault pin level at completion |
| faulting | output | NDEV | Per-device "do not trust data" mask |

## Verification
The bench builds the block with NDEV=3, DIV=2 and per-device fault pins. Three devices are enough to place a fault on the first, the middle and the last device in one frame. This covers both edges of the byte-to-device mapping. With a divider of 2, every frame stays under 200 cycles. The per-device pins let a single frame mix a faulting device with healthy neighbours, and this is what proves that the flags stay independent per device. A scoreboard of expected results, computed from a division-based CRC model, is compared at every `done` pulse.

// File: rtl/cr_pkg.sv
package cr_pkg;
   // generator x^5+x^4+x^2+1 without its leading term
   localparam logic [4:0] CRC5_GEN = 5'h15;

   function automatic logic [4:0] crc5_step(input logic [4:0] cur, input logic din);
      logic fb;
      fb = cur[4] ^ din;
      return {cur[3:0], 1'b0} ^ (fb ? CRC5_GEN : 5'h00);
   endfunction
endpackage

// File: rtl/cr_sclk_engine.sv
module cr_sclk_engine #(
   parameter int DIV = 2,
   parameter int CW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] nbits,
   input  logic          miso,
   output logic          sclk,
   output logic          cs_n,
   output logic          busy,
   output logic          bit_stb,
   output logic          bit_val,
   output logic          end_stb
);
   localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [DW-1:0] div_cnt;
   logic [CW-1:0] bit_cnt;
   logic          tick;

   assign tick = (div_cnt == DW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk    <= 1'b0;
         cs_n    <= 1'b1;
         busy    <= 1'b0;
         bit_stb <= 1'b0;
         bit_val <= 1'b0;
         end_stb <= 1'b0;
         div_cnt <= '0;
         bit_cnt <= '0;
      end else begin
         bit_stb <= 1'b0;
         end_stb <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               cs_n    <= 1'b0;
               sclk    <= 1'b0;
               div_cnt <= '0;
               bit_cnt <= '0;
            end
         end else if (tick) begin
            div_cnt <= '0;
            if (!sclk) begin
               sclk    <= 1'b1;
               bit_stb <= 1'b1;
               bit_val <= miso;
            end else begin
               sclk <= 1'b0;
               if (bit_cnt == nbits - CW'(1)) begin
                  busy    <= 1'b0;
                  cs_n    <= 1'b1;
                  end_stb <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + CW'(1);
               end
            end
         end else begin
            div_cnt <= div_cnt + DW'(1);
         end
      end
   end

   // R1
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R1
   bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && busy) |-> (bit_cnt < nbits));

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/cr_dev_slot.sv
module cr_dev_slot (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       wr_data,
   input  logic       wr_stat,
   input  logic [7:0] byte_in,
   input  logic [4:0] crc_ref,
   input  logic       commit,
   input  logic       mode16,
   input  logic       ign,
   input  logic       fault_pin,
   output logic [7:0] data_q,
   output logic       crc_q,
   output logic       ot_q,
   output logic       uva_q,
   output logic       uvw_q,
   output logic       flt_q,
   output logic       bad_q
);
   logic [7:0] s_data;
   logic       s_crc, s_ot, s_uva, s_uvw;
   logic       bad_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_data <= '0;
         s_crc  <= 1'b0;
         s_ot   <= 1'b0;
         s_uva  <= 1'b0;
         s_uvw  <= 1'b0;
      end else if (clear) begin
         s_data <= '0;
         s_crc  <= 1'b0;
         s_ot   <= 1'b0;
         s_uva  <= 1'b0;
         s_uvw  <= 1'b0;
      end else begin
         if (wr_data) s_data <= byte_in;
         if (wr_stat) begin
            s_crc <= (byte_in[7:3] != crc_ref);
            s_ot  <= byte_in[1];
            s_uva <= ~byte_in[2];
            s_uvw <= ~byte_in[0];
         end
      end
   end

   assign bad_nx = (!ign && fault_pin) ||
                   (mode16 && (s_crc || s_ot || (!ign && s_uva)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         crc_q  <= 1'b0;
         ot_q   <= 1'b0;
         uva_q  <= 1'b0;
         uvw_q  <= 1'b0;
         flt_q  <= 1'b0;
         bad_q  <= 1'b0;
      end else if (commit) begin
         data_q <= s_data;
         crc_q  <= s_crc;
         ot_q   <= s_ot;
         uva_q  <= s_uva;
         uvw_q  <= s_uvw;
         flt_q  <= fault_pin;
         bad_q  <= bad_nx;
      end
   end
endmodule

// File: rtl/cr_frame_check.sv
module cr_frame_check #(
   parameter int NDEV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              mode16,
   input  logic              ign,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              end_stb,
   input  logic [NDEV-1:0]   fault_vec,
   output logic              done,
   output logic [NDEV*8-1:0] din_vec,
   output logic [NDEV-1:0]   crc_err,
   output logic [NDEV-1:0]   over_temp,
   output logic [NDEV-1:0]   uv_alarm,
   output logic [NDEV-1:0]   uv_warn,
   output logic [NDEV-1:0]   fault_seen,
   output logic [NDEV-1:0]   faulting
);
   import cr_pkg::*;

   localparam int BW = (NDEV > 0) ? $clog2(2 * NDEV) : 1;

   logic [2:0]    bit_pos;
   logic [BW-1:0] byte_idx;
   logic [BW-1:0] dev;
   logic [6:0]    shreg;
   logic [4:0]    crc, crc_hold;
   logic [7:0]    byte_val;
   logic          is_stat, byte_end;

   assign byte_val = {shreg, bit_val};
   assign is_stat  = mode16 && byte_idx[0];
   assign dev      = mode16 ? (byte_idx >> 1) : byte_idx;
   assign byte_end = bit_stb && (bit_pos == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_pos  <= '0;
         byte_idx <= '0;
         shreg    <= '0;
         crc      <= '0;
         crc_hold <= '0;
      end else if (clear) begin
         bit_pos  <= '0;
         byte_idx <= '0;
         shreg    <= '0;
         crc      <= '0;
         crc_hold <= '0;
      end else if (bit_stb) begin
         shreg   <= byte_val[6:0];
         bit_pos <= bit_pos + 3'd1;
         if (!is_stat) begin
            if (bit_pos == 3'd7) begin
               crc      <= '0;
               crc_hold <= crc5_step(crc, bit_val);
            end else begin
               crc <= crc5_step(crc, bit_val);
            end
         end
         if (bit_pos == 3'd7) byte_idx <= byte_idx + BW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= end_stb;
   end

   for (genvar g = 0; g < NDEV; g++) begin : g_slot
      logic sel;
      assign sel = (dev == BW'(g));
      cr_dev_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (clear),
         .wr_data   (byte_end && sel && !is_stat),
         .wr_stat   (byte_end && sel && is_stat),
         .byte_in   (byte_val),
         .crc_ref   (crc_hold),
         .commit    (end_stb),
         .mode16    (mode16),
         .ign       (ign),
         .fault_pin (fault_vec[g]),
         .data_q    (din_vec[8*g +: 8]),
         .crc_q     (crc_err[g]),
         .ot_q      (over_temp[g]),
         .uva_q     (uv_alarm[g]),
         .uvw_q     (uv_warn[g]),
         .flt_q     (fault_seen[g]),
         .bad_q     (faulting[g])
      );
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   stable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(faulting) && $stable(din_vec) && $stable(crc_err)));

   // R2
   commit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_stb |-> (bit_pos == 3'd0));
endmodule

// File: rtl/chain_reader.sv
module chain_reader #(
   parameter int NDEV         = 4,
   parameter int DIV          = 2,
   parameter int FAULT_SHARED = 0,
   localparam int FW          = (FAULT_SHARED != 0) ? 1 : NDEV
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode16,
   input  logic              ignore_uv,
   input  logic [FW-1:0]     fault_in,
   input  logic              miso,
   output logic              sclk,
   output logic              cs_n,
   output logic              busy,
   output logic              done,
   output logic [NDEV*8-1:0] din_vec,
   output logic [NDEV-1:0]   crc_err,
   output logic [NDEV-1:0]   over_temp,
   output logic [NDEV-1:0]   uv_alarm,
   output logic [NDEV-1:0]   uv_warn,
   output logic [NDEV-1:0]   fault_seen,
   output logic [NDEV-1:0]   faulting
);
   localparam int CW = $clog2(NDEV * 16 + 1);

   if (NDEV < 1) begin : g_bad_ndev
      $error("chain_reader: NDEV must be at least 1");
   end
   if (DIV < 1) begin : g_bad_div
      $error("chain_reader: DIV must be at least 1");
   end

   logic            accept, mode_q, ign_q;
   logic [CW-1:0]   nbits;
   logic [NDEV-1:0] fault_vec;
   logic            bit_stb, bit_val, end_stb;

   assign accept = start && !busy;
   assign nbits  = mode_q ? CW'(NDEV * 16) : CW'(NDEV * 8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         ign_q  <= 1'b0;
      end else if (accept) begin
         mode_q <= mode16;
         ign_q  <= ignore_uv;
      end
   end

   if (FAULT_SHARED != 0) begin : g_fault_shared
      assign fault_vec = {NDEV{fault_in[0]}};
   end else begin : g_fault_each
      assign fault_vec = fault_in;
   end

   cr_sclk_engine #(.DIV(DIV), .CW(CW)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .nbits   (nbits),
      .miso    (miso),
      .sclk    (sclk),
      .cs_n    (cs_n),
      .busy    (busy),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .end_stb (end_stb)
   );

   cr_frame_check #(.NDEV(NDEV)) u_chk (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .mode16     (mode_q),
      .ign        (ign_q),
      .bit_stb    (bit_stb),
      .bit_val    (bit_val),
      .end_stb    (end_stb),
      .fault_vec  (fault_vec),
      .done       (done),
      .din_vec    (din_vec),
      .crc_err    (crc_err),
      .over_temp  (over_temp),
      .uv_alarm   (uv_alarm),
      .uv_warn    (uv_warn),
      .fault_seen (fault_seen),
      .faulting   (faulting)
   );

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !accept) |=> ($stable(mode_q) && $stable(ign_q)));
endmodule

// File: tb/chain_reader_test.sv
`timescale 1ns/1ps
module chain_reader_test;
   localparam int NDEV = 3;
   localparam int DIV  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, mode16 = 1'b0, ignore_uv = 1'b0;
   logic [NDEV-1:0] fault_in = '0;
   logic miso;
   logic sclk, cs_n, busy, done;
   logic [NDEV*8-1:0] din_vec;
   logic [NDEV-1:0] crc_err, over_temp, uv_alarm, uv_warn, fault_seen, faulting;

   always #2 clk = ~clk;

   chain_reader #(.NDEV(NDEV), .DIV(DIV), .FAULT_SHARED(0)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode16(mode16),
      .ignore_uv(ignore_uv), .fault_in(fault_in), .miso(miso),
      .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done),
      .din_vec(din_vec), .crc_err(crc_err), .over_temp(over_temp),
      .uv_alarm(uv_alarm), .uv_warn(uv_warn), .fault_seen(fault_seen),
      .faulting(faulting)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // chain model: serves a byte list MSB first, advancing on SCLK falling edges
   logic [7:0] fbytes [2*NDEV];
   int falls = 0;
   int base  = 0;
   int edges = 0;
   int edges_at_start = 0;

   always @(negedge sclk) falls++;
   always @(negedge cs_n) base = falls;
   always @(posedge sclk) if (!cs_n) edges++;
   always_comb begin : chain_out
      int k;
      k = falls - base;
      if (k >= 0 && k < 16 * NDEV) miso = fbytes[k / 8][7 - (k % 8)];
      else miso = 1'b0;
   end

   // reference CRC by polynomial long division of data*x^5
   function automatic logic [4:0] ref_crc(input logic [7:0] d);
      logic [12:0] m;
      m = {d, 5'b0};
      for (int i = 12; i >= 5; i--)
         if (m[i]) m = m ^ (13'b110101 << (i - 5));
      return m[4:0];
   endfunction

   function automatic logic [7:0] good_stat(input logic [7:0] d);
      return {ref_crc(d), 3'b101};
   endfunction

   typedef struct {
      logic [NDEV*8-1:0] din;
      logic [NDEV-1:0]   crc, ot, uva, uvw, flt, fing;
      int                nedges;
      bit                m16, ign, poke;
   } exp_t;

   exp_t q[$];

   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q.size() == 0) begin
            total++; bad++;
            $display("FAIL R8 unexpected done act=1 exp=0");
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.poke ? "R10 edge count" : "R1 edge count",
                64'(edges - edges_at_start), 64'(e.nedges));
            chk("R2 din_vec", 64'(din_vec), 64'(e.din));
            chk(e.m16 ? "R3 crc_err" : "R5 crc_err", 64'(crc_err), 64'(e.crc));
            chk(e.m16 ? "R4 over_temp" : "R5 over_temp", 64'(over_temp), 64'(e.ot));
            chk(e.m16 ? "R4 uv_alarm" : "R5 uv_alarm", 64'(uv_alarm), 64'(e.uva));
            chk(e.m16 ? "R4 uv_warn" : "R5 uv_warn", 64'(uv_warn), 64'(e.uvw));
            chk(e.ign ? "R7 fault_seen" : "R6 fault_seen", 64'(fault_seen), 64'(e.flt));
            chk(e.poke ? "R10 faulting" : (e.ign ? "R7 faulting" : "R6 faulting"),
                64'(faulting), 64'(e.fing));
         end
      end
   end

   task automatic run_frame(input logic [NDEV*8-1:0] dv, input logic [NDEV*8-1:0] sv,
                            input bit m16, input bit ign, input logic [NDEV-1:0] fp,
                            input bit poke);
      exp_t e;
      e.din = dv; e.m16 = m16; e.ign = ign; e.poke = poke;
      e.nedges = NDEV * 8 * (m16 ? 2 : 1);
      for (int i = 0; i < NDEV; i++) begin
         logic [7:0] d, s;
         d = dv[8*i +: 8];
         s = sv[8*i +: 8];
         if (m16) begin
            fbytes[2*i]     = d;
            fbytes[2*i + 1] = s;
            e.crc[i] = (s[7:3] != ref_crc(d));
            e.ot[i]  = s[1];
            e.uva[i] = ~s[2];
            e.uvw[i] = ~s[0];
         end else begin
            fbytes[i] = d;
            e.crc[i] = 1'b0; e.ot[i] = 1'b0; e.uva[i] = 1'b0; e.uvw[i] = 1'b0;
         end
         e.flt[i]  = fp[i];
         e.fing[i] = (!ign && fp[i]) || (m16 && (e.crc[i] || e.ot[i] || (!ign && e.uva[i])));
      end
      q.push_back(e);
      @(negedge clk);
      mode16 = m16; ignore_uv = ign; fault_in = fp;
      edges_at_start = edges;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (6) @(negedge clk);
         mode16 = ~m16; ignore_uv = ~ign;
         start = 1'b1;                 // R8: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (8) @(negedge clk);
      chk("R8 hold faulting", 64'(faulting), 64'(e.fing));
      chk("R8 hold din_vec", 64'(din_vec), 64'(e.din));
      chk("R8 done low", 64'(done), 64'(0));
      mode16 = m16; ignore_uv = ign;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [7:0] a0, a1, a2;
      for (int i = 0; i < 2*NDEV; i++) fbytes[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 cs_n", 64'(cs_n), 64'(1));
      chk("R9 sclk", 64'(sclk), 64'(0));
      chk("R9 busy", 64'(busy), 64'(0));
      chk("R9 done", 64'(done), 64'(0));
      chk("R9 faulting", 64'(faulting), 64'(0));
      chk("R9 din_vec", 64'(din_vec), 64'(0));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // all healthy, long mode
      run_frame({8'h00, 8'h3C, 8'hA5},
                {good_stat(8'h00), good_stat(8'h3C), good_stat(8'hA5)}, 1, 0, 3'b000, 0);
      // middle device CRC corrupted, last device overtemperature
      run_frame({8'h7E, 8'hC3, 8'h5A},
                {good_stat(8'h7E) | 8'h02, good_stat(8'hC3) ^ 8'h08, good_stat(8'h5A)},
                1, 0, 3'b000, 0);
      // first device undervoltage alarm, middle warning only, last fault pin
      a0 = good_stat(8'h11) & 8'hFB;
      a1 = good_stat(8'h22) & 8'hFE;
      a2 = good_stat(8'h33);
      run_frame({8'h33, 8'h22, 8'h11}, {a2, a1, a0}, 1, 0, 3'b100, 0);
      // same with undervoltage ignored
      run_frame({8'h33, 8'h22, 8'h11}, {a2, a1, a0}, 1, 1, 3'b100, 0);
      // short mode, fault pin on middle device
      run_frame({8'h80, 8'h01, 8'hFF}, '0, 0, 0, 3'b010, 0);
      // short mode with every fault pin high but ignored
      run_frame({8'h0F, 8'hF0, 8'h81}, '0, 0, 1, 3'b111, 0);
      // long mode, config inputs flipped and start re-pulsed mid-readout
      run_frame({8'h0F, 8'h69, 8'h96},
                {good_stat(8'h0F), good_stat(8'h69) | 8'h02, good_stat(8'h96)},
                1, 0, 3'b001, 1);

      repeat (20) @(negedge clk);
      chk("R8 queue empty", 64'(q.size()), 64'(0));
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule